// File: doc/BRIEF.md
# Banked Control Register File

This block holds the system-control registers of a multithreaded core. Each register is reached by a register number and a select. It is kept either as one shared copy, as one copy per virtual processing element, or as one copy per hardware thread. Every access carries a thread ID. For a per-thread register, the thread ID picks the copy directly. For a per-element register, the copy is picked by the element-binding field of that thread's binding register.

The block has one combinational read port and one write port. The write port carries an operation code, which selects one of three actions:
- a masked write, which keeps every bit that is clear in the register's write mask;
- a raw write, which stores the value unchanged;
- a load of the write mask of the addressed copy.

A masked write also schedules a thread re-evaluation for the next cycle. In that evaluation, each thread within the configured thread count is marked halted or released, from its halt bit and its activated bit. The result drives one halt output per thread.

Top module: `cop_ctlreg_file`

## Requirements
- R1: The flat register index is {num, sel}, which equals num*8+sel. There are 8 selects for each register number, and each (num, sel) pair is a distinct register.
- R2: Banking depends on the register:
  - Register number 2 with select 1 to 7, and register (12,0), are per-thread. The copy used is the one of the accessing thread ID.
  - Register number 1 with select 1 to 7 is per-element. The copy used is chosen by bits [EW-1:0] of the binding register (2,2) of the accessing thread.
  - All other registers are shared.
- R3: Write op 1 (masked) stores (data & mask) | (old & ~mask) into the addressed copy.
- R4: Write op 2 (raw) stores the data unchanged. Write op 3 replaces only the write mask of the addressed copy.
- R5: A masked write taken at one clock edge causes re-evaluation at the following edge. There, a thread's halt output becomes H | ~A, where:
  - H is bit 0 of its halt register (2,4);
  - A is bit 15 of its status register (2,1).
  Raw writes and mask loads trigger no re-evaluation.
- R6: Only threads t <= bits [7:0] of the shared configuration register (0,2) are re-evaluated. The halt outputs of the other threads keep their value.
- R7: At reset, register (0,2) holds NTHR-1 in bits [7:0] and NELEM-1 in bits [15:8].
- R8: At reset, the thread status register (2,1) holds 0x8000 for thread 0 and 0x0080 for every other thread. The halt output resets to all ones except thread 0.
- R9: At reset:
  - (1,0) holds 63 with mask 0;
  - (15,0) holds PRID_VAL with mask 0;
  - (15,1) holds 0x80000000 with mask 0x3FFFF000.
- R10: At reset, every copy of register (12,0) holds 0x10400004, with mask 0xFF78FF17.
- R11: Every other register copy resets to 0 with an all-ones mask.
- R12: A read is combinational from the stored copy. A read of the copy being written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_tid | input | TW | Thread ID of the read |
| rd_num | input | NW | Register number of the read |
| rd_sel | input | 3 | Select of the read |
| rd_data | output | 32 | Read data |
| wr_op | input | 2 | 0 none, 1 masked write, 2 raw write, 3 mask load |
| wr_tid | input | TW | Thread ID of the write |
| wr_num | input | NW | Register number of the write |
| wr_sel | input | 3 | Select of the write |
| wr_data | input | 32 | Write data or mask value |
| halt | output | NTHR | Per-thread halt state |

## Verification
Two functions can coincide in one cycle:
- **Read and write of the same copy.** The bench holds the read port on a register while a masked write to that register is presented. It samples before the edge, where it expects the old value, and again after the edge, where it expects the merged value.
- **Write and deferred re-evaluation.** A masked write can be accepted in the same cycle in which the re-evaluation for an earlier write is still pending. To judge this, the halt outputs are sampled in two places: in the cycle after the write, where they must be unchanged, and one cycle later, where they must hold the value that the bench computes from the halt and activated bits it last wrote. The thread-count limit is checked the same way, by shrinking the count so that a thread whose bits changed must keep its old halt state.

// File: rtl/cop_ctlreg_file.sv
module cop_ctlreg_file #(
  parameter int NTHR = 4,
  parameter int NELEM = 2,
  parameter int NRNUM = 16,
  parameter logic [31:0] PRID_VAL = 32'h0002_A401,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int NW = $clog2(NRNUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    rd_tid,
  input  logic [NW-1:0]    rd_num,
  input  logic [2:0]       rd_sel,
  output logic [31:0]      rd_data,
  input  logic [1:0]       wr_op,
  input  logic [TW-1:0]    wr_tid,
  input  logic [NW-1:0]    wr_num,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [NTHR-1:0]  halt
);
  localparam int NIDX = NRNUM * 8;
  localparam int IW = NW + 3;
  localparam int EW = (NELEM > 1) ? $clog2(NELEM) : 1;
  localparam logic [IW-1:0] IX_CFG   = IW'(2);
  localparam logic [IW-1:0] IX_RAND  = IW'(8);
  localparam logic [IW-1:0] IX_TSTAT = IW'(17);
  localparam logic [IW-1:0] IX_TBIND = IW'(18);
  localparam logic [IW-1:0] IX_THALT = IW'(20);
  localparam logic [IW-1:0] IX_STAT  = IW'(96);
  localparam logic [IW-1:0] IX_PRID  = IW'(120);
  localparam logic [IW-1:0] IX_EBASE = IW'(121);
  localparam logic [1:0] OP_MASKED = 2'd1, OP_RAW = 2'd2, OP_LDMASK = 2'd3;
  localparam logic [31:0] STAT_MASK = 32'hFF78_FF17;
  localparam logic [31:0] EBASE_MASK = 32'h3FFF_F000;

  logic [31:0] dat [NIDX][NTHR];
  logic [31:0] msk [NIDX][NTHR];
  logic [NTHR-1:0] halt_q;
  logic upd_pend;

  function automatic logic per_thr(input logic [IW-1:0] ix);
    return (ix[IW-1:3] == NW'(2) && ix[2:0] != 3'd0) || ix == IX_STAT;
  endfunction

  function automatic logic per_elem(input logic [IW-1:0] ix);
    return ix[IW-1:3] == NW'(1) && ix[2:0] != 3'd0;
  endfunction

  function automatic logic [31:0] rst_dat(input logic [IW-1:0] ix, input int s);
    case (ix)
      IX_CFG:   return {16'h0, 8'(NELEM - 1), 8'(NTHR - 1)};
      IX_RAND:  return 32'd63;
      IX_TSTAT: return (s == 0) ? 32'h0000_8000 : 32'h0000_0080;
      IX_STAT:  return 32'h1040_0004;
      IX_PRID:  return PRID_VAL;
      IX_EBASE: return 32'h8000_0000;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] rst_msk(input logic [IW-1:0] ix);
    case (ix)
      IX_RAND, IX_PRID: return 32'h0;
      IX_STAT:          return STAT_MASK;
      IX_EBASE:         return EBASE_MASK;
      default:          return 32'hFFFF_FFFF;
    endcase
  endfunction

  wire [IW-1:0] rd_ix = {rd_num, rd_sel};
  wire [IW-1:0] wr_ix = {wr_num, wr_sel};
  logic [TW-1:0] rd_slot, wr_slot;
  logic [31:0] rd_bind, wr_bind;

  assign rd_bind = dat[IX_TBIND][rd_tid];
  assign wr_bind = dat[IX_TBIND][wr_tid];

  always_comb begin
    rd_slot = '0;
    if (per_thr(rd_ix)) rd_slot = rd_tid;
    else if (per_elem(rd_ix)) rd_slot = TW'(rd_bind[EW-1:0]);
    wr_slot = '0;
    if (per_thr(wr_ix)) wr_slot = wr_tid;
    else if (per_elem(wr_ix)) wr_slot = TW'(wr_bind[EW-1:0]);
  end

  assign rd_data = dat[rd_ix][rd_slot];
  wire [31:0] wr_cur = dat[wr_ix][wr_slot];
  wire [31:0] wr_msk = msk[wr_ix][wr_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIDX; i++)
        for (int s = 0; s < NTHR; s++) begin
          dat[i][s] <= rst_dat(IW'(i), s);
          msk[i][s] <= rst_msk(IW'(i));
        end
      upd_pend <= 1'b0;
    end else begin
      upd_pend <= (wr_op == OP_MASKED);
      case (wr_op)
        OP_MASKED: dat[wr_ix][wr_slot] <= (wr_data & wr_msk) | (wr_cur & ~wr_msk);
        OP_RAW:    dat[wr_ix][wr_slot] <= wr_data;
        OP_LDMASK: msk[wr_ix][wr_slot] <= wr_data;
        default: ;
      endcase
    end
  end

  wire [7:0] thr_last = dat[IX_CFG][0][7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= {{(NTHR-1){1'b1}}, 1'b0};
    end else if (upd_pend) begin
      for (int t = 0; t < NTHR; t++)
        if (32'(t) <= {24'h0, thr_last})
          halt_q[t] <= dat[IX_THALT][t][0] | ~dat[IX_TSTAT][t][15];
    end
  end

  assign halt = halt_q;

  logic chk_v;
  logic [IW-1:0] chk_i;
  logic [TW-1:0] chk_s;
  logic [31:0] chk_m, chk_keep;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v <= 1'b0; chk_i <= '0; chk_s <= '0; chk_m <= '0; chk_keep <= '0;
    end else begin
      chk_v <= (wr_op == OP_MASKED);
      chk_i <= wr_ix; chk_s <= wr_slot;
      chk_m <= wr_msk; chk_keep <= wr_cur & ~wr_msk;
    end
  end

  assert_keep_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> ((dat[chk_i][chk_s] & ~chk_m) == chk_keep));

  assert_no_spurious_eval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op != OP_MASKED) |=> ##1 $stable(halt_q));

  assert_ro_random_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msk[IX_RAND][0] == 32'h0 && !(wr_op == OP_RAW && wr_ix == IX_RAND)) |=> $stable(dat[IX_RAND][0]));

  for (genvar g = 0; g < NTHR; g++) begin : g_lim
    assert_out_of_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_pend && 32'(g) > {24'h0, thr_last}) |=> $stable(halt_q[g]));
  end
endmodule

// File: tb/sim_cop_ctlreg_file.sv
`timescale 1ns/1ps
module sim_cop_ctlreg_file;
  localparam int NTHR = 4;
  localparam logic [31:0] PRID = 32'h0002_A401;
  localparam logic [31:0] SMASK = 32'hFF78_FF17;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rd_tid = '0, wr_tid = '0;
  logic [3:0] rd_num = '0, wr_num = '0;
  logic [2:0] rd_sel = '0, wr_sel = '0;
  logic [1:0] wr_op = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NTHR-1:0] halt;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  cop_ctlreg_file u0 (.clk(clk), .rst_n(rst_n), .rd_tid(rd_tid), .rd_num(rd_num),
    .rd_sel(rd_sel), .rd_data(rd_data), .wr_op(wr_op), .wr_tid(wr_tid),
    .wr_num(wr_num), .wr_sel(wr_sel), .wr_data(wr_data), .halt(halt));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] o, input int tid, input int num, input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_op = o; wr_tid = 2'(tid); wr_num = 4'(num); wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_op = 2'd0;
  endtask

  task automatic rdchk(input string tag, input int tid, input int num, input int sel, input logic [31:0] exp);
    rd_tid = 2'(tid); rd_num = 4'(num); rd_sel = 3'(sel);
    #1;
    check(tag, rd_data, exp);
  endtask

  function automatic logic [31:0] exp_rst(input int ix, input int tid);
    case (ix)
      2:   return 32'h0000_0103;
      8:   return 32'd63;
      17:  return (tid == 0) ? 32'h8000 : 32'h80;
      96:  return 32'h1040_0004;
      120: return PRID;
      121: return 32'h8000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rst_tag(input int ix);
    case (ix)
      2: return "R7";
      17: return "R8";
      8, 120, 121: return "R9";
      96: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] m, o, n, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R8 halt reset", 32'(halt), 32'hE);
    for (int num = 0; num < 16; num++)
      for (int sel = 0; sel < 8; sel++)
        for (int t = 0; t < NTHR; t++)
          rdchk(rst_tag(num * 8 + sel), t, num, sel, exp_rst(num * 8 + sel, t));

    // R1 select split
    for (int s = 0; s < 8; s++) op(2'd2, 0, 6, s, 32'h600 + 32'(s));
    for (int s = 0; s < 8; s++) begin
      rdchk("R1 sel", 0, 6, s, 32'h600 + 32'(s));
      rdchk("R1 neighbour", 0, 7, s, 32'h0);
    end

    // R9 read-only fields
    op(2'd1, 0, 1, 0, 32'hFFFF_FFFF); rdchk("R9 random", 0, 1, 0, 32'd63);
    op(2'd1, 2, 15, 0, 32'h0);        rdchk("R9 prid", 0, 15, 0, PRID);
    op(2'd1, 1, 15, 1, 32'hFFFF_FFFF); rdchk("R9 ebase set", 3, 15, 1, 32'hBFFF_F000);
    op(2'd1, 0, 15, 1, 32'h0);        rdchk("R9 ebase clr", 0, 15, 1, 32'h8000_0000);

    // R10 status mask
    op(2'd1, 1, 12, 0, 32'hFFFF_FFFF);
    rdchk("R10 status", 1, 12, 0, SMASK | (32'h1040_0004 & ~SMASK));
    rdchk("R10 other thread", 2, 12, 0, 32'h1040_0004);

    // R3 / R4 mask merge sweep
    for (int k = 0; k < 16; k++) begin
      m = (32'h9E37_79B9 * 32'(k + 1)) ^ (32'(k) << 7);
      o = (32'h85EB_CA6B * 32'(k + 3)) ^ 32'h0F0F_0F0F;
      n = (32'hC2B2_AE35 * 32'(k + 5)) + 32'(k);
      op(2'd3, k % 4, 5, 3, m);
      op(2'd2, k % 4, 5, 3, o);
      rdchk("R4 raw", (k + 1) % 4, 5, 3, o);
      op(2'd1, k % 4, 5, 3, n);
      rdchk("R3 merge", (k + 2) % 4, 5, 3, (n & m) | (o & ~m));
    end
    op(2'd3, 1, 2, 6, 32'h0000_FFFF);
    op(2'd2, 1, 2, 6, 32'h0);
    op(2'd1, 1, 2, 6, 32'hFFFF_FFFF);
    op(2'd1, 2, 2, 6, 32'hFFFF_FFFF);
    rdchk("R4 mask load thr1", 1, 2, 6, 32'h0000_FFFF);
    rdchk("R4 mask other thr2", 2, 2, 6, 32'hFFFF_FFFF);

    // R2 banking
    for (int t = 0; t < NTHR; t++) op(2'd1, t, 2, 5, 32'h100 * 32'(t) + 32'h11);
    for (int t = 0; t < NTHR; t++) rdchk("R2 per-thread", t, 2, 5, 32'h100 * 32'(t) + 32'h11);
    op(2'd1, 3, 5, 4, 32'hCAFE_0005);
    rdchk("R2 shared", 0, 5, 4, 32'hCAFE_0005);
    op(2'd2, 1, 2, 2, 32'h1);
    op(2'd2, 3, 2, 2, 32'h1);
    a = 32'hA0A0_1234; b = 32'hB0B0_5678;
    op(2'd1, 0, 1, 3, a);
    op(2'd1, 1, 1, 3, b);
    rdchk("R2 elem0 via thr2", 2, 1, 3, a);
    rdchk("R2 elem1 via thr3", 3, 1, 3, b);
    rdchk("R2 elem0 via thr0", 0, 1, 3, a);

    // R5 halt evaluation timing
    @(negedge clk); #1;
    check("R5 halt before", 32'(halt), 32'hE);
    op(2'd2, 1, 2, 1, 32'h8000);
    @(negedge clk); #1;
    check("R5 raw no eval", 32'(halt), 32'hE);
    op(2'd1, 0, 5, 3, 32'h1);
    #1; check("R5 not yet", 32'(halt), 32'hE);
    @(negedge clk); #1;
    check("R5 released thr1", 32'(halt), 32'hC);
    op(2'd2, 0, 2, 4, 32'h1);
    op(2'd1, 0, 5, 3, 32'h2);
    @(negedge clk); #1;
    check("R5 H halts thr0", 32'(halt), 32'hD);

    // R6 thread count limit
    op(2'd2, 0, 2, 4, 32'h0);
    op(2'd2, 0, 0, 2, 32'h0000_0101);
    op(2'd2, 2, 2, 1, 32'h8000);
    op(2'd1, 0, 5, 3, 32'h3);
    @(negedge clk); #1;
    check("R6 limited count", 32'(halt), 32'hC);
    op(2'd2, 0, 0, 2, 32'h0000_0103);
    op(2'd1, 0, 5, 3, 32'h4);
    @(negedge clk); #1;
    check("R6 full count", 32'(halt), 32'h8);

    // R12 same-cycle read and write
    op(2'd2, 0, 5, 7, 32'h1111);
    @(negedge clk);
    rd_tid = 2'd0; rd_num = 4'd5; rd_sel = 3'd7;
    wr_op = 2'd1; wr_tid = 2'd0; wr_num = 4'd5; wr_sel = 3'd7; wr_data = 32'h2222;
    #1; check("R12 old value", rd_data, 32'h1111);
    @(negedge clk);
    wr_op = 2'd0;
    #1; check("R12 new value", rd_data, 32'h2222);

    finish_run();
  end
endmodule